// File: doc/BRIEF.md
# Region-Based Memory Protection Unit

This block checks each memory access against a set of programmable protection regions and returns the access attributes together with a verdict. Instruction fetches are compared only against a bank of instruction regions. Loads and stores are compared only against a separate bank of data regions. Each region has a base address, a power-of-two size and an 8-bit attribute word. When no enabled region in the selected bank matches, one global default attribute word supplies the attributes. A miss does not fault by itself.

A single register write port programs the regions. Each write selects a bank, a region index and a field. Field code 0 writes the base from `wrData[ADDR_W-1:12]`. Field code 1 writes the size code from `wrData[3:0]`. Field code 2 writes the region attribute from `wrData[7:0]`. Field code 3 writes the global default attribute from `wrData[7:0]`; for this code the bank and the index are ignored. The address check is combinational and the verdict is registered, so the result of an access appears one cycle after it is presented.

The attribute word has this bit layout:

| Bit | Meaning |
|---|---|
| 0 | Supervisor read |
| 1 | Supervisor write |
| 2 | Supervisor execute |
| 3 | User read |
| 4 | User write |
| 5 | User execute |
| 6 | Speculation allowed |
| 7 | Region enabled |

Top module: `mpu_guard`

## Requirements
- R1: After reset, all outputs are 0, every region is disabled, and the default attribute is 0x7F.
- R2: A fetch (`accFetch`=1) is compared only against the instruction bank (`wrBank`=0). A load or store is compared only against the data bank (`wrBank`=1).
- R3: A size code c from 0 to 12 selects a region of 4 KB·2^c. Codes 13 to 15 act as 16 MB.
- R4: A region matches when the address bits at and above the region size equal the base bits at and above the region size. Base bits below the size are ignored.
- R5: When several regions in the selected bank match, the lowest-numbered region supplies the attributes, and `outHit`=1.
- R6: When no enabled region in the selected bank matches, `outHit`=0 and `outAttr` equals the default attribute.
- R7: Only one permission bit from the attribute layout above is checked. A fetch checks execute and ignores `accWrite`. A load checks read. A store checks write. The user bit is checked when `accUser`=1, otherwise the supervisor bit.
- R8: A non-speculative access whose permission bit is 0 gives `outFault`=1 for that one result cycle, with `outGrant`=0.
- R9: A speculative access (`accSpec`=1) never faults. It is granted only if its permission bit is 1 and attribute bit 6 is 1; otherwise it is blocked silently.
- R10: A result appears exactly one cycle after the access, with `outValid`=1. In a cycle after `accValid`=0, all outputs are 0.
- R11: A region whose attribute bit 7 is 0 never matches. Writes take effect for accesses from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrBank | input | 1 | Bank select: 0 selects instruction, 1 selects data |
| wrIdx | input | IDX_W | Region index within the bank |
| wrField | input | 2 | Field select: 0 base, 1 size, 2 attribute, 3 default attribute |
| wrData | input | ADDR_W | Write data |
| accValid | input | 1 | Access present |
| accAddr | input | ADDR_W | Access address |
| accFetch | input | 1 | 1 for an instruction fetch |
| accWrite | input | 1 | 1 for a store |
| accUser | input | 1 | 1 for user mode |
| accSpec | input | 1 | 1 for a speculative access |
| outValid | output | 1 | Result valid |
| outHit | output | 1 | A region matched |
| outAttr | output | 8 | Resolved attribute word |
| outGrant | output | 1 | Access allowed |
| outFault | output | 1 | Protection fault pulse |

## Verification
The assertions check the following on every cycle:
- fault and grant never appear together;
- a speculative access never faults, and is never granted unless the resolved attributes allow speculation;
- a fetch faults exactly when its execute bit for the current mode is clear;
- a reported hit always carries an enabled attribute word;
- idle cycles leave every output quiet.

Only the bench scenarios can show the following:
- bank separation;
- the size decoding, including the clamped codes;
- tolerance of a misaligned base;
- lowest-index priority;
- the fall-through to the default entry;
- that disabling a region takes effect.

These all depend on the programmed region contents, so the bench compares every cycle against its own reference model.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int ATTR_W  = 8;
  localparam int A_SR    = 0;
  localparam int A_SW    = 1;
  localparam int A_SX    = 2;
  localparam int A_UR    = 3;
  localparam int A_UW    = 4;
  localparam int A_UX    = 5;
  localparam int A_SPEC  = 6;
  localparam int A_EN    = 7;
  localparam logic [ATTR_W-1:0] DEF_ATTR_RST = 8'h7F;

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_SIZE = 2'd1,
    FLD_ATTR = 2'd2,
    FLD_DEF  = 2'd3
  } wrField_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       wrBase;
    logic       wrSize;
    logic       wrAttr;
    logic       wrDef;
    logic [7:0] slot;
    logic       capture;
    logic       bankData;
    logic [2:0] permSel;
    logic       spec;
  } mpuStrb_t;
endpackage

// File: rtl/mpu_ctrl.sv
module mpu_ctrl
  import mpu_pkg::*;
#(
  parameter int NUM_REG = 4,
  localparam int IDX_W = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic             wrEn,
  input  logic             wrBank,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [1:0]       wrField,
  input  logic             accValid,
  input  logic             accFetch,
  input  logic             accWrite,
  input  logic             accUser,
  input  logic             accSpec,
  output mpuStrb_t         strb
);
  wrField_e fieldSel;
  assign fieldSel = wrField_e'(wrField);

  always_comb begin
    strb = '0;
    strb.wrBase = wrEn && (fieldSel == FLD_BASE);
    strb.wrSize = wrEn && (fieldSel == FLD_SIZE);
    strb.wrAttr = wrEn && (fieldSel == FLD_ATTR);
    strb.wrDef  = wrEn && (fieldSel == FLD_DEF);
    strb.slot   = 8'(wrBank ? (NUM_REG + int'(wrIdx)) : int'(wrIdx));
    strb.capture  = accValid;
    strb.bankData = !accFetch;
    strb.spec     = accSpec;
    if (accFetch)      strb.permSel = 3'(accUser ? A_UX : A_SX);
    else if (accWrite) strb.permSel = 3'(accUser ? A_UW : A_SW);
    else               strb.permSel = 3'(accUser ? A_UR : A_SR);
  end
endmodule

// File: rtl/mpu_dpath.sv
module mpu_dpath
  import mpu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_REG = 4,
  parameter int MIN_LOG = 12,
  parameter int MAX_LOG = 24,
  parameter int SZ_W    = 4,
  localparam int PAGE_W = ADDR_W - MIN_LOG,
  localparam int SLOTS  = 2 * NUM_REG,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int MAX_CODE = MAX_LOG - MIN_LOG
) (
  input  logic              clk,
  input  logic              rst,
  input  mpuStrb_t          strb,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              outValid,
  output logic              outHit,
  output logic [ATTR_W-1:0] outAttr,
  output logic              outGrant,
  output logic              outFault
);
  logic [PAGE_W-1:0] baseQ [SLOTS];
  logic [SZ_W-1:0]   sizeQ [SLOTS];
  logic [ATTR_W-1:0] attrQ [SLOTS];
  logic [ATTR_W-1:0] defQ;
  logic [SLOT_W-1:0] wrSlot;

  assign wrSlot = strb.slot[SLOT_W-1:0];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) begin
        baseQ[i] <= '0;
        sizeQ[i] <= '0;
        attrQ[i] <= '0;
      end
      defQ <= DEF_ATTR_RST;
    end else begin
      if (strb.wrBase) baseQ[wrSlot] <= wrData[ADDR_W-1:MIN_LOG];
      if (strb.wrSize) sizeQ[wrSlot] <= wrData[SZ_W-1:0];
      if (strb.wrAttr) attrQ[wrSlot] <= wrData[ATTR_W-1:0];
      if (strb.wrDef)  defQ <= wrData[ATTR_W-1:0];
    end
  end

  logic [PAGE_W-1:0] accPage;
  logic [NUM_REG-1:0] hitVec;
  logic [ATTR_W-1:0]  bankAttr [NUM_REG];
  assign accPage = accAddr[ADDR_W-1:MIN_LOG];

  for (genvar g = 0; g < NUM_REG; g++) begin : g_cmp
    logic [PAGE_W-1:0] rBase;
    logic [SZ_W-1:0]   rSize;
    logic [SZ_W-1:0]   shAmt;
    logic [PAGE_W-1:0] mask;
    assign rBase = strb.bankData ? baseQ[NUM_REG+g] : baseQ[g];
    assign rSize = strb.bankData ? sizeQ[NUM_REG+g] : sizeQ[g];
    assign bankAttr[g] = strb.bankData ? attrQ[NUM_REG+g] : attrQ[g];
    assign shAmt = (int'(rSize) > MAX_CODE) ? SZ_W'(MAX_CODE) : rSize;
    assign mask  = {PAGE_W{1'b1}} << shAmt;
    assign hitVec[g] = bankAttr[g][A_EN] && (((accPage ^ rBase) & mask) == '0);
  end

  logic              anyHit;
  logic [ATTR_W-1:0] selAttr;
  always_comb begin
    anyHit  = 1'b0;
    selAttr = defQ;
    for (int i = NUM_REG - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        anyHit  = 1'b1;
        selAttr = bankAttr[i];
      end
    end
  end

  logic permOk, grantD, faultD;
  assign permOk = selAttr[strb.permSel];
  assign grantD = permOk && (!strb.spec || selAttr[A_SPEC]);
  assign faultD = !permOk && !strb.spec;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      outValid <= 1'b0;
      outHit   <= 1'b0;
      outAttr  <= '0;
      outGrant <= 1'b0;
      outFault <= 1'b0;
    end else begin
      outValid <= strb.capture;
      outHit   <= strb.capture && anyHit;
      outAttr  <= strb.capture ? selAttr : '0;
      outGrant <= strb.capture && grantD;
      outFault <= strb.capture && faultD;
    end
  end
endmodule

// File: rtl/mpu_guard.sv
module mpu_guard
  import mpu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_REG = 4,
  localparam int IDX_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              wrBank,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [1:0]        wrField,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accFetch,
  input  logic              accWrite,
  input  logic              accUser,
  input  logic              accSpec,
  output logic              outValid,
  output logic              outHit,
  output logic [7:0]        outAttr,
  output logic              outGrant,
  output logic              outFault
);
  mpuStrb_t strb;

  mpu_ctrl #(.NUM_REG(NUM_REG)) u_ctrl (
    .wrEn(wrEn), .wrBank(wrBank), .wrIdx(wrIdx), .wrField(wrField),
    .accValid(accValid), .accFetch(accFetch), .accWrite(accWrite),
    .accUser(accUser), .accSpec(accSpec), .strb(strb)
  );

  mpu_dpath #(.ADDR_W(ADDR_W), .NUM_REG(NUM_REG)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData), .accAddr(accAddr),
    .outValid(outValid), .outHit(outHit), .outAttr(outAttr),
    .outGrant(outGrant), .outFault(outFault)
  );
endmodule

// File: rtl/mpu_guard_chk.sv
module mpu_guard_chk
  import mpu_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       accValid,
  input logic       accFetch,
  input logic       accUser,
  input logic       accSpec,
  input logic       outValid,
  input logic       outHit,
  input logic [7:0] outAttr,
  input logic       outGrant,
  input logic       outFault
);
  AST_FAULT_NOT_GRANT: assert property (@(posedge clk) disable iff (rst)
    !(outFault && outGrant)); // R8
  AST_SPEC_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    (accValid && accSpec) |=> !outFault); // R9
  AST_SPEC_GATE: assert property (@(posedge clk) disable iff (rst)
    (accValid && accSpec) |=> (!outGrant || outAttr[A_SPEC])); // R9
  AST_FETCH_PERM: assert property (@(posedge clk) disable iff (rst)
    (accValid && accFetch && !accSpec) |=>
      (outFault == !($past(accUser) ? outAttr[A_UX] : outAttr[A_SX]))); // R7
  AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (rst)
    outHit |-> outAttr[A_EN]); // R11
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    accValid |=> outValid); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !accValid |=> (!outValid && !outHit && !outGrant && !outFault && outAttr == 8'h00)); // R10
endmodule

bind mpu_guard mpu_guard_chk u_chk (
  .clk(clk), .rst(rst), .accValid(accValid), .accFetch(accFetch),
  .accUser(accUser), .accSpec(accSpec), .outValid(outValid), .outHit(outHit),
  .outAttr(outAttr), .outGrant(outGrant), .outFault(outFault)
);

// File: tb/mpu_guard_tb.sv
module mpu_guard_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0, wrBank = 1'b0;
  logic [1:0]  wrIdx = '0, wrField = '0;
  logic [31:0] wrData = '0, accAddr = '0;
  logic        accValid = 1'b0, accFetch = 1'b0, accWrite = 1'b0, accUser = 1'b0, accSpec = 1'b0;
  logic        outValid, outHit, outGrant, outFault;
  logic [7:0]  outAttr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mpu_guard u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrBank(wrBank), .wrIdx(wrIdx),
    .wrField(wrField), .wrData(wrData), .accValid(accValid), .accAddr(accAddr),
    .accFetch(accFetch), .accWrite(accWrite), .accUser(accUser), .accSpec(accSpec),
    .outValid(outValid), .outHit(outHit), .outAttr(outAttr),
    .outGrant(outGrant), .outFault(outFault)
  );

  // reference model state: slots 0..3 instruction, 4..7 data
  logic [31:0] mBase [8];
  int          mSize [8];
  logic [7:0]  mAttr [8];
  logic [7:0]  mDef;

  logic       eV, eH, eG, eF;
  logic [7:0] eA;
  string      pendTag = "R1";

  task automatic compare();
    checks++;
    if (outValid !== eV || outHit !== eH || outAttr !== eA || outGrant !== eG || outFault !== eF) begin
      errors++;
      $display("FAIL %s: got v%b h%b a%02h g%b f%b expected v%b h%b a%02h g%b f%b",
               pendTag, outValid, outHit, outAttr, outGrant, outFault, eV, eH, eA, eG, eF);
    end
  endtask

  task automatic expectIdle(string tag);
    {eV, eH, eG, eF} = 4'b0;
    eA = 8'h00;
    pendTag = tag;
  endtask

  task automatic doIdle(string tag);
    @(negedge clk);
    compare();
    wrEn = 1'b0;
    accValid = 1'b0;
    expectIdle(tag);
  endtask

  task automatic doWrite(input logic bank, input int idx, input int field,
                         input logic [31:0] data, input string tag);
    @(negedge clk);
    compare();
    accValid = 1'b0;
    wrEn = 1'b1;
    wrBank = bank;
    wrIdx = 2'(idx);
    wrField = 2'(field);
    wrData = data;
    case (field)
      0: mBase[(bank ? 4 : 0) + idx] = data >> 12;
      1: mSize[(bank ? 4 : 0) + idx] = int'(data[3:0]);
      2: mAttr[(bank ? 4 : 0) + idx] = data[7:0];
      default: mDef = data[7:0];
    endcase
    expectIdle(tag);
  endtask

  task automatic doAcc(input logic [31:0] a, input logic fetch, input logic wr,
                       input logic usr, input logic spec, input string tag);
    int off, hitIdx, sh, bitSel;
    logic [7:0] at;
    logic perm;
    @(negedge clk);
    compare();
    wrEn = 1'b0;
    accValid = 1'b1;
    accAddr = a;
    accFetch = fetch;
    accWrite = wr;
    accUser = usr;
    accSpec = spec;
    off = fetch ? 0 : 4;
    hitIdx = -1;
    for (int i = 3; i >= 0; i--) begin
      sh = (mSize[off+i] > 12) ? 12 : mSize[off+i];
      if (mAttr[off+i][7] && ((((a >> 12) ^ mBase[off+i]) >> sh) == 32'd0)) hitIdx = i;
    end
    at = (hitIdx >= 0) ? mAttr[off+hitIdx] : mDef;
    if (fetch)   bitSel = usr ? 5 : 2;
    else if (wr) bitSel = usr ? 4 : 1;
    else         bitSel = usr ? 3 : 0;
    perm = at[bitSel];
    eV = 1'b1;
    eH = (hitIdx >= 0);
    eA = at;
    eG = perm && (!spec || at[6]);
    eF = !perm && !spec;
    pendTag = tag;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      mBase[i] = '0;
      mSize[i] = 0;
      mAttr[i] = '0;
    end
    mDef = 8'h7F;
    expectIdle("R1");
    repeat (3) begin
      @(negedge clk);
      compare();
    end
    rst = 1'b0;
    doAcc(32'h0001_2345, 1, 0, 0, 0, "R1 R6 default after reset");
    doWrite(0, 0, 0, 32'h0001_0000, "R11 write");
    doWrite(0, 0, 1, 32'd4,         "R11 write");
    doWrite(0, 0, 2, 32'hE4,        "R11 write");
    doWrite(1, 0, 0, 32'h0001_7000, "R11 write");
    doWrite(1, 0, 1, 32'd4,         "R11 write");
    doWrite(1, 0, 2, 32'h8B,        "R11 write");
    doWrite(1, 1, 0, 32'h0000_0000, "R11 write");
    doWrite(1, 1, 1, 32'd12,        "R11 write");
    doWrite(1, 1, 2, 32'hFF,        "R11 write");
    doAcc(32'h0001_2345, 1, 0, 1, 0, "R2 fetch uses instruction bank");
    doAcc(32'h0001_2345, 0, 0, 0, 0, "R2 R5 load uses data bank, lowest index");
    doAcc(32'h0001_0004, 0, 0, 1, 0, "R4 misaligned base ignored");
    doAcc(32'h0001_0010, 0, 1, 1, 0, "R8 user store fault");
    doIdle("R8 R10 fault lasts one cycle");
    doAcc(32'h0001_0010, 0, 0, 1, 1, "R9 speculative blocked silently");
    doAcc(32'h0001_0000, 1, 0, 0, 1, "R9 speculative granted");
    doAcc(32'h0002_0000, 1, 0, 0, 0, "R6 instruction miss uses default");
    doAcc(32'h0002_0000, 0, 1, 1, 0, "R3 R5 16MB data region");
    doAcc(32'h0100_0000, 0, 0, 0, 0, "R3 beyond 16MB misses");
    doWrite(0, 1, 0, 32'h0040_0000, "R11 write");
    doWrite(0, 1, 1, 32'd0,         "R11 write");
    doWrite(0, 1, 2, 32'hE4,        "R11 write");
    doAcc(32'h0040_0FFF, 1, 0, 0, 0, "R3 4KB top inside");
    doAcc(32'h0040_1000, 1, 0, 0, 0, "R3 4KB just outside");
    doWrite(0, 2, 0, 32'h0200_0000, "R11 write");
    doWrite(0, 2, 1, 32'd15,        "R11 write");
    doWrite(0, 2, 2, 32'hA4,        "R11 write");
    doAcc(32'h02FF_FFF0, 1, 0, 1, 0, "R3 code 15 acts as 16MB");
    doAcc(32'h0300_0000, 1, 0, 1, 0, "R3 code 15 upper bound");
    doAcc(32'h02FF_FFF0, 1, 1, 1, 1, "R7 R9 fetch ignores write, spec off");
    doWrite(0, 0, 2, 32'h64,        "R11 write");
    doAcc(32'h0001_2345, 1, 0, 0, 0, "R11 disabled region ignored");
    doWrite(0, 0, 3, 32'h00,        "R11 write");
    doAcc(32'h0100_0000, 0, 0, 0, 0, "R6 R8 default denies");
    doAcc(32'h0100_0000, 0, 0, 0, 1, "R9 default denies speculative");
    doAcc(32'h0001_0020, 0, 1, 0, 0, "R7 supervisor store granted");
    doAcc(32'h0001_0020, 0, 0, 1, 0, "R7 user load granted");
    doIdle("R10 idle");
    doIdle("R10 idle");
    @(negedge clk);
    compare();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule